// File: doc/BRIEF.md
# Working Register File on a Shared Data Bus

This block holds eight one-byte working registers for a small 8-bit processor whose modules all meet on one shared data bus. An access takes two steps. First a 3-bit register number is captured into an internal address register by a separate address strobe. Then a read strobe or a write strobe acts on the entry that this captured number selects. A write copies the bus value into that entry. A read drives the entry onto the bus.

The shared bus is modelled as three ports: an input from the bus, an output towards the bus, and an output that enables the drive. The bus drive also needs an active-low output-enable input to be asserted.

All strobes are sampled on the system clock, and only their rising edges start an action. The read path and the write path never act together. When the read and write strobes rise on the same clock, neither action takes place, and a sticky conflict flag is raised instead.

Top module: `wreg_file`

## Requirements
- R1: A synchronous active-high reset clears all eight entries, the captured address and the conflict flag. While the bus is not being driven, `bus_oe` is 0.
- R2: A 0-to-1 change of `addr_stb` between clock samples loads `addr_in` into the captured address. After that, accesses use the captured address, and changes on `addr_in` alone have no effect.
- R3: A rising edge of `wr_stb`, without a rising edge of `rd_stb` and with no read active, stores `bus_in` into the entry selected by the captured address. Every other entry keeps its value.
- R4: A rising edge of `rd_stb`, without a rising edge of `wr_stb`, starts a read from the next clock. While `oe_n` is 0, `bus_oe` is then 1 and `bus_out` shows the value of the selected entry as it was at that edge. The value stays constant until `rd_stb` is sampled low.
- R5: When no read is active, or when `oe_n` is 1, `bus_oe` is 0 and `bus_out` is 0.
- R6: When `rd_stb` and `wr_stb` rise on the same clock, both are ignored and `conflict` becomes 1. It stays at 1 until reset.
- R7: A rising edge of `wr_stb` while a read is active is ignored, so the entry keeps its value.
- R8: Actions occur only on rising edges of the strobes. If a strobe is held high, the action is not repeated: a write stores only the bus value present at the edge.
- R9: If `oe_n` goes to 1 during a read, the bus is released. If `oe_n` returns to 0 while `rd_stb` is still held high, the same read value is driven again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | 3 | Register number to capture |
| addr_stb | input | 1 | Address capture strobe, acts on its rising edge |
| rd_stb | input | 1 | Read strobe, acts on its rising edge |
| wr_stb | input | 1 | Write strobe, acts on its rising edge |
| oe_n | input | 1 | Active-low enable of the bus drive |
| bus_in | input | 8 | Value currently on the shared bus |
| bus_out | output | 8 | Value driven towards the bus, 0 when not driving |
| bus_oe | output | 1 | Bus drive enable |
| conflict | output | 1 | Sticky flag for simultaneous read and write edges |

## Verification
Distinct values are written into every entry and then read back one by one. This separates a wrong decode, which shows up as aliased or missing entries, from a wrong storage path. Several patterns target specific faults:
- Changing `addr_in` without a strobe separates the captured address from the live one.
- Holding `wr_stb` high while the bus value changes shows whether writes are edge-triggered.
- Raising `wr_stb` during an active read shows whether the read/write exclusion is enforced.
- Raising both strobes together shows whether the conflict handling works.
- Toggling `oe_n` in the middle of a read shows whether the bus is released and then driven again.

// File: rtl/wreg_file.sv
module wreg_file #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              addr_stb,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              conflict
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ent [DEPTH];
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rd_data;
  logic              a_q, r_q, w_q, rd_active;
  logic [DEPTH-1:0]  wr_hot, rd_hot;

  wire a_rise = addr_stb & ~a_q;
  wire r_rise = rd_stb & ~r_q;
  wire w_rise = wr_stb & ~w_q;
  wire do_rd  = r_rise & ~w_rise;
  wire do_wr  = w_rise & ~r_rise & ~rd_active;

  always_comb begin
    wr_hot = '0;
    rd_hot = '0;
    for (int i = 0; i < DEPTH; i++) begin
      wr_hot[i] = do_wr && (addr_q == ADDR_W'(i));
      rd_hot[i] = do_rd && (addr_q == ADDR_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= 1'b0;
      r_q <= 1'b0;
      w_q <= 1'b0;
      addr_q <= '0;
      conflict <= 1'b0;
      rd_active <= 1'b0;
      rd_data <= '0;
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else begin
      a_q <= addr_stb;
      r_q <= rd_stb;
      w_q <= wr_stb;
      if (a_rise) addr_q <= addr_in;
      if (r_rise && w_rise) conflict <= 1'b1;
      if (do_rd) rd_active <= 1'b1;
      else if (!rd_stb) rd_active <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_hot[i]) ent[i] <= bus_in;
        if (rd_hot[i]) rd_data <= ent[i];
      end
    end
  end

  assign bus_oe  = rd_active & ~oe_n;
  assign bus_out = bus_oe ? rd_data : '0;
endmodule

module wreg_file_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic              oe_n,
  input logic [DATA_W-1:0] bus_out,
  input logic              bus_oe,
  input logic              conflict
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!conflict && !bus_oe));
  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_out == '0));
  // R5
  drive_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> (!oe_n && $past(rd_stb)));
  // R4
  read_value_held_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_out));
  // R6
  conflict_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    conflict |=> conflict);
  // R6
  conflict_raise_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_stb) && $rose(wr_stb) && !$past(rst)) |=> conflict);
endmodule

bind wreg_file wreg_file_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb), .oe_n(oe_n),
  .bus_out(bus_out), .bus_oe(bus_oe), .conflict(conflict)
);

// File: tb/wreg_file_test.sv
module wreg_file_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr_in = '0;
  logic       addr_stb = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0, oe_n = 1'b0;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_out;
  logic       bus_oe, conflict;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  wreg_file uut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .addr_stb(addr_stb),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .oe_n(oe_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .conflict(conflict)
  );

  always #(PERIOD/2) clk = ~clk;

  int   m_mem [8];
  int   m_addr = 0, m_rdval = 0;
  bit   m_read = 0, m_conf = 0, pa = 0, pr = 0, pw = 0;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_addr = 0; m_rdval = 0; m_read = 0; m_conf = 0; pa = 0; pr = 0; pw = 0;
    end else begin
      bit ar, rr, wr;
      ar = addr_stb && !pa;
      rr = rd_stb && !pr;
      wr = wr_stb && !pw;
      if (rr && wr) m_conf = 1;
      else if (wr && !m_read) m_mem[m_addr] = int'(bus_in);
      if (rr && !wr) begin
        m_read = 1;
        m_rdval = m_mem[m_addr];
      end else if (!rd_stb) m_read = 0;
      if (ar) m_addr = int'(addr_in);
      pa = addr_stb; pr = rd_stb; pw = wr_stb;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit eoe;
      int eout;
      eoe = m_read && !oe_n;
      eout = eoe ? m_rdval : 0;
      check(bus_oe === eoe, "R5 bus_oe vs model", int'(bus_oe), int'(eoe));
      check(int'(bus_out) == eout && !$isunknown(bus_out), "R4 bus_out vs model",
            int'(bus_out), eout);
      check(conflict === m_conf, "R6 conflict vs model", int'(conflict), int'(m_conf));
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic latch(int a);
    addr_in = 3'(a); addr_stb = 1; step();
    addr_stb = 0; step();
  endtask

  task automatic write(int d);
    bus_in = 8'(d); wr_stb = 1; step();
    wr_stb = 0; step();
  endtask

  task automatic read_chk(int exp, string tag);
    rd_stb = 1; step();
    check(bus_oe === 1'b1 && int'(bus_out) == exp, tag, int'(bus_out), exp);
    rd_stb = 0; step(); step();
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    step(); step();
    rst = 0; step();
    check(conflict === 1'b0 && bus_oe === 1'b0, "R1 reset outputs", int'(conflict), 0);
    for (int i = 0; i < 8; i++) begin
      latch(i);
      read_chk(0, "R1 entry cleared");
    end
    for (int i = 0; i < 8; i++) begin
      latch(i);
      write(8'h13 * i + 8'h21);
    end
    for (int i = 7; i >= 0; i--) begin
      latch(i);
      read_chk((8'h13 * i + 8'h21) & 8'hff, "R3 write/readback");
    end
    latch(5);
    addr_in = 3'd2; step();
    write(8'hA5);
    read_chk(8'hA5, "R2 captured address used");
    latch(2);
    read_chk(8'h13 * 2 + 8'h21, "R2 live address ignored");
    latch(1);
    bus_in = 8'h3C; wr_stb = 1; step();
    bus_in = 8'hC3; step(); step();
    wr_stb = 0; step();
    read_chk(8'h3C, "R8 held strobe no repeat");
    latch(4);
    rd_stb = 1; step();
    bus_in = 8'hFF; wr_stb = 1; step();
    wr_stb = 0; rd_stb = 0; step(); step();
    read_chk(8'h13 * 4 + 8'h21, "R7 write during read ignored");
    latch(3);
    rd_stb = 1; step();
    oe_n = 1; step();
    check(bus_oe === 1'b0 && bus_out === 8'h00, "R9 released on oe_n high", int'(bus_out), 0);
    oe_n = 0; step();
    check(bus_oe === 1'b1 && int'(bus_out) == 8'h13 * 3 + 8'h21, "R9 drive restored",
          int'(bus_out), 8'h13 * 3 + 8'h21);
    rd_stb = 0; step(); step();
    check(bus_oe === 1'b0, "R5 idle after read", int'(bus_oe), 0);
    latch(6);
    bus_in = 8'h77; rd_stb = 1; wr_stb = 1; step();
    check(conflict === 1'b1 && bus_oe === 1'b0, "R6 conflict raised", int'(conflict), 1);
    rd_stb = 0; wr_stb = 0; step(); step();
    check(conflict === 1'b1, "R6 conflict sticky", int'(conflict), 1);
    read_chk(8'h13 * 6 + 8'h21, "R6 simultaneous write ignored");
    rst = 1; step();
    rst = 0; step();
    check(conflict === 1'b0, "R1 conflict cleared", int'(conflict), 0);
    latch(5);
    read_chk(0, "R1 entries cleared again");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule